// File: doc/BRIEF.md
# Control-Word Parity Out-of-Service Tracker

This block decides whether a receive link is fit for use. It watches the per-word parity verdicts of the control words that land in each clock cycle, on up to eight lanes at once. It keeps the link out of service until enough consecutive clean cycles have been seen. Once the link is in service, it takes it out again after enough consecutive corrupted cycles. The two run lengths come from separate 4-bit inputs, which gives independent hysteresis in each direction. The parity itself is computed upstream. This block only sees one good/bad bit per lane, qualified by a valid bit.

The control is a two-state machine. `ST_OOS` means the link is out of service, and `ST_INSVC` means it is in service. Two transitions connect them. RESTORE goes from `ST_OOS` to `ST_INSVC` when the clean-run counter reaches the restore level. FAIL goes from `ST_INSVC` to `ST_OOS` when the corrupt-run counter reaches the fail level. A cycle counts as clean only if every valid word in it is good. It counts as corrupt only if every valid word in it is bad. A mixed cycle resets whichever counter is active, so more than the fail level of bad words can pass before FAIL is taken. A further output reports when either level is programmed to zero, which is an illegal setting.

Top module: `cw_parity_oos`

## Requirements
- R1: During and after reset, `oos_flag` is 1 (state `ST_OOS`) and both run counters are zero.
- R2: Lanes with `cw_valid` low are ignored. A cycle is clean when at least one lane is valid and every valid lane has `cw_dip_ok`=1. It is corrupt when at least one lane is valid and every valid lane has `cw_dip_ok`=0.
- R3: In `ST_OOS` a clean cycle raises the clean-run count by one. If that incremented count is at least `restore_level`, `oos_flag` drops to 0 right after that cycle's clock edge (RESTORE).
- R4: In `ST_OOS` a cycle with valid words that is not clean (mixed or corrupt) sets the clean-run count to zero.
- R5: In `ST_INSVC` a corrupt cycle raises the corrupt-run count by one. If that incremented count is at least `fail_level`, `oos_flag` rises to 1 right after that cycle's clock edge (FAIL).
- R6: In `ST_INSVC` a cycle with valid words that is not corrupt sets the corrupt-run count to zero.
- R7: A cycle in which no lane is valid leaves both counts and `oos_flag` unchanged.
- R8: `level_err` is 1, combinationally, whenever `restore_level` or `fail_level` equals 0. While it is 1, `oos_flag` does not change, although the counts still advance.
- R9: The run counts saturate at 15 and never wrap to zero.
- R10: Both run counts clear on every RESTORE and every FAIL, so each new run starts from zero.
- R11: Every one of the `NUM_LANES` lane positions contributes in the same way, and all of them can be valid in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | NUM_LANES | A control word is present on this lane this cycle |
| cw_dip_ok | input | NUM_LANES | Parity verdict of the word on this lane, 1 = good |
| restore_level | input | LVL_W | Clean cycles needed to leave out-of-service (1..15) |
| fail_level | input | LVL_W | Corrupt cycles needed to enter out-of-service (1..15) |
| oos_flag | output | 1 | 1 while the link is out of service |
| level_err | output | 1 | 1 while either level input is zero |

## Verification
The bench builds the block with its defaults: eight lanes and 4-bit levels. With eight lanes, every lane position and the widest mixed-verdict patterns can be exercised. With 4-bit levels, the saturating count of 15 can be reached in a short run. Holding a level at zero for twenty clean cycles and then setting it to 15 shows whether a counter has wrapped. Random levels between 1 and 15, with an occasional zero, drive both transitions back and forth across many hysteresis settings.

// File: rtl/cw_oos_pkg.sv
package cw_oos_pkg;

    typedef enum logic {
        ST_OOS   = 1'b0,
        ST_INSVC = 1'b1
    } link_state_t;

    typedef struct packed {
        logic any;
        logic clean;
        logic corrupt;
    } cycle_class_t;

endpackage

// File: rtl/cw_lane_classifier.sv
module cw_lane_classifier
    import cw_oos_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic [NUM_LANES-1:0] lane_valid,
    input  logic [NUM_LANES-1:0] lane_ok,
    output cycle_class_t         cls
);

    logic [NUM_LANES-1:0] lane_pass;
    logic [NUM_LANES-1:0] lane_fail;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // an idle lane never vetoes either verdict
        assign lane_pass[i] = !lane_valid[i] || lane_ok[i];
        assign lane_fail[i] = !lane_valid[i] || !lane_ok[i];
    end

    always_comb begin
        cls.any     = |lane_valid;
        cls.clean   = cls.any && (&lane_pass);
        cls.corrupt = cls.any && (&lane_fail);
    end

endmodule

// File: rtl/cw_run_counter.sv
module cw_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign cnt_inc = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt_inc;
        end
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R9

    AST_CNT_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt)); // R7

endmodule

// File: rtl/cw_oos_fsm.sv
module cw_oos_fsm
    import cw_oos_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cycle_class_t     cls,
    input  logic [LVL_W-1:0] good_inc,
    input  logic [LVL_W-1:0] bad_inc,
    input  logic [LVL_W-1:0] restore_level,
    input  logic [LVL_W-1:0] fail_level,
    input  logic             levels_ok,
    output link_state_t      state,
    output logic             good_clr,
    output logic             good_step,
    output logic             bad_clr,
    output logic             bad_step
);

    link_state_t state_nxt;
    logic        switching;

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OOS: begin
                if (cls.clean && levels_ok && good_inc >= restore_level)
                    state_nxt = ST_INSVC;   // RESTORE
            end
            ST_INSVC: begin
                if (cls.corrupt && levels_ok && bad_inc >= fail_level)
                    state_nxt = ST_OOS;     // FAIL
            end
            default: state_nxt = ST_OOS;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OOS;
        else        state <= state_nxt;
    end

    // counter controls
    always_comb begin
        switching = (state_nxt != state);
        good_clr  = 1'b0;
        good_step = 1'b0;
        bad_clr   = 1'b0;
        bad_step  = 1'b0;
        unique case (state)
            ST_OOS: begin
                bad_clr   = 1'b1;
                good_clr  = switching || (cls.any && !cls.clean);
                good_step = cls.clean;
            end
            ST_INSVC: begin
                good_clr  = 1'b1;
                bad_clr   = switching || (cls.any && !cls.corrupt);
                bad_step  = cls.corrupt;
            end
            default: begin
                good_clr = 1'b1;
                bad_clr  = 1'b1;
            end
        endcase
    end

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cls.any |=> $stable(state)); // R7

    AST_ZERO_LEVEL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !levels_ok |=> $stable(state)); // R8

    AST_RESTORE_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OOS && !cls.clean) |=> (state == ST_OOS)); // R3

    AST_FAIL_NEEDS_CORRUPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSVC && !cls.corrupt) |=> (state == ST_INSVC)); // R5

endmodule

// File: rtl/cw_parity_oos.sv
module cw_parity_oos
    import cw_oos_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int LVL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] cw_valid,
    input  logic [NUM_LANES-1:0] cw_dip_ok,
    input  logic [LVL_W-1:0]     restore_level,
    input  logic [LVL_W-1:0]     fail_level,
    output logic                 oos_flag,
    output logic                 level_err
);

    cycle_class_t     cls;
    link_state_t      state;
    logic             levels_ok;
    logic             good_clr, good_step, bad_clr, bad_step;
    logic [LVL_W-1:0] good_cnt, good_inc, bad_cnt, bad_inc;

    assign levels_ok = (restore_level != '0) && (fail_level != '0);

    cw_lane_classifier #(.NUM_LANES(NUM_LANES)) u_classify (
        .lane_valid (cw_valid),
        .lane_ok    (cw_dip_ok),
        .cls        (cls)
    );

    cw_run_counter #(.CNT_W(LVL_W)) u_good_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (good_clr),
        .inc     (good_step),
        .cnt     (good_cnt),
        .cnt_inc (good_inc)
    );

    cw_run_counter #(.CNT_W(LVL_W)) u_bad_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (bad_clr),
        .inc     (bad_step),
        .cnt     (bad_cnt),
        .cnt_inc (bad_inc)
    );

    cw_oos_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cls           (cls),
        .good_inc      (good_inc),
        .bad_inc       (bad_inc),
        .restore_level (restore_level),
        .fail_level    (fail_level),
        .levels_ok     (levels_ok),
        .state         (state),
        .good_clr      (good_clr),
        .good_step     (good_step),
        .bad_clr       (bad_clr),
        .bad_step      (bad_step)
    );

    always_comb begin
        oos_flag  = (state == ST_OOS);
        level_err = !levels_ok;
    end

    AST_INACTIVE_GOOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSVC) |-> (good_cnt == '0)); // R10

    AST_INACTIVE_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OOS) |-> (bad_cnt == '0)); // R10

    AST_MIXED_RESETS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OOS && cls.any && !cls.clean) |=> (good_cnt == '0)); // R4

    AST_MIXED_RESETS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSVC && cls.any && !cls.corrupt) |=> (bad_cnt == '0)); // R6

endmodule

// File: tb/cw_parity_oos_tb.sv
module cw_parity_oos_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int LW = 4;
    localparam logic [NW-1:0] ALL = {NW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] cw_valid = '0;
    logic [NW-1:0] cw_dip_ok = '0;
    logic [LW-1:0] restore_level = 4'd3;
    logic [LW-1:0] fail_level = 4'd2;
    logic          oos_flag;
    logic          level_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit m_oos = 1'b1;
    int m_gc = 0;
    int m_bc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cw_parity_oos #(.NUM_LANES(NW), .LVL_W(LW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cw_valid      (cw_valid),
        .cw_dip_ok     (cw_dip_ok),
        .restore_level (restore_level),
        .fail_level    (fail_level),
        .oos_flag      (oos_flag),
        .level_err     (level_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat_inc(input int c);
        return (c >= 15) ? 15 : c + 1;
    endfunction

    // reference model of one cycle, written from the requirements
    task automatic model_step(input logic [NW-1:0] v, input logic [NW-1:0] g);
        bit any, clean, corrupt, ok;
        int n;
        any     = (v != '0);
        clean   = any && ((g | ~v) == ALL);
        corrupt = any && ((~g | ~v) == ALL);
        ok      = (restore_level != 0) && (fail_level != 0);
        if (!any) return;
        if (m_oos) begin
            if (clean) begin
                n = sat_inc(m_gc);
                if (ok && n >= int'(restore_level)) begin
                    m_oos = 1'b0; m_gc = 0; m_bc = 0;
                end else m_gc = n;
            end else m_gc = 0;
        end else begin
            if (corrupt) begin
                n = sat_inc(m_bc);
                if (ok && n >= int'(fail_level)) begin
                    m_oos = 1'b1; m_gc = 0; m_bc = 0;
                end else m_bc = n;
            end else m_bc = 0;
        end
    endtask

    task automatic apply(input logic [NW-1:0] v, input logic [NW-1:0] g, input string tag);
        @(negedge clk);
        cw_valid  = v;
        cw_dip_ok = g;
        #1;
        chk({tag, " R8 level_err"}, int'(level_err),
            int'(restore_level == 0 || fail_level == 0));
        model_step(v, g);
        @(posedge clk);
        #1;
        chk({tag, " oos_flag"}, int'(oos_flag), int'(m_oos));
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flag in reset", int'(oos_flag), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 flag after reset", int'(oos_flag), 1);

        // R3: three clean cycles restore (level 3), R10 counters fresh
        apply(ALL, ALL, "R3 clean 1");
        apply(ALL, ALL, "R3 clean 2");
        apply(ALL, ALL, "R3 clean 3 restore");
        // R5 / R6: bad, mixed, bad, bad -> fail at level 2
        apply(ALL, '0,      "R5 corrupt 1");
        apply(ALL, 8'hF0,   "R6 mixed resets");
        apply(ALL, '0,      "R6 corrupt after reset");
        apply(ALL, '0,      "R5 corrupt fail");
        // R10 / R4: after FAIL the clean run restarts; mixed resets it
        apply(ALL, ALL,     "R10 clean 1");
        apply(ALL, ALL,     "R10 clean 2");
        apply(ALL, 8'h7F,   "R4 mixed resets");
        apply(ALL, ALL,     "R4 clean 1");
        apply(ALL, ALL,     "R4 clean 2");
        apply(ALL, ALL,     "R4 clean 3 restore");
        // R7: idle cycles keep the count
        apply(ALL, '0,      "R7 corrupt 1");
        apply('0,  '0,      "R7 idle");
        apply('0,  ALL,     "R7 idle ok bits");
        apply(ALL, '0,      "R7 corrupt 2 fail");
        // R2: invalid lanes ignored
        apply(8'h0F, 8'h0F, "R2 partial clean 1");
        apply(8'h0F, 8'h0F, "R2 partial clean 2");
        apply(8'hC0, 8'hC3, "R2 partial clean 3");
        apply(8'h30, 8'hCF, "R2 partial corrupt");
        apply(8'h81, 8'h7E, "R2 partial corrupt 2 fail");
        // R11: each lane alone
        restore_level = 4'd8;
        for (int i = 0; i < NW; i++) begin
            apply(NW'(1) << i, NW'(1) << i, "R11 single lane");
        end
        // R8 / R9: zero level freezes flag, count saturates at 15
        fail_level = 4'd0;
        for (int i = 0; i < 20; i++) apply(ALL, '0, "R8 frozen corrupt");
        fail_level = 4'd15;
        apply(ALL, '0, "R9 saturated fail");
        restore_level = 4'd0;
        for (int i = 0; i < 20; i++) apply(ALL, ALL, "R8 frozen clean");
        restore_level = 4'd15;
        apply(ALL, ALL, "R9 saturated restore");

        // constrained random run
        for (int n = 0; n < 4000; n++) begin
            logic [NW-1:0] v, g;
            int r;
            if ((n % 97) == 0) begin
                restore_level = LW'(($urandom % 15) + 1);
                fail_level    = LW'(($urandom % 15) + 1);
                if (($urandom % 10) == 0) restore_level = '0;
                if (($urandom % 10) == 0) fail_level = '0;
            end
            v = NW'($urandom);
            if (($urandom % 5) == 0) v = '0;
            r = $urandom % 10;
            if (r < 4)      g = ALL;
            else if (r < 8) g = '0;
            else            g = NW'($urandom);
            apply(v, g, "R2 R3 R4 R5 R6 random");
        end

        done = 1;
        report();
    end

endmodule